// File: doc/BRIEF.md
# Dual-Mode Bus Slave with Internal Address Latch

This block is the peripheral side of a shared 8-bit address/data bus that fronts a 256-entry register file. A static mode input picks one of two strobe conventions. The first uses an active-low read strobe and an active-low write strobe. The second uses an active-high data strobe plus a read/not-write level. In both conventions an address-strobe pin and one active-low select complete the interface. Every bus input crosses into the system clock through two flip-flops. Strobe edges are found by comparing consecutive synchronized samples.

On a multiplexed host, the address-strobe pin marks the address phase, and the falling edge of that pin loads the address register. A host with separate address and data buses has no such signal. That host wires its lowest address bit to the address-strobe pin. A write ending while the pin is high then loads the address register from the bus, and it does not touch the register file. A later access with the pin low moves the data. So each register access takes two host cycles: an address write to an odd byte, then a data read or write to an even byte. Both ways of loading the address feed the same register, and the capture that happened last is the one that counts.

Top module: `dmbus_slave`

## Requirements
- R1: After reset every register reads 0x00, the address register is 0x00, `ad_oe` is 0 and `ad_out` is 0x00.
- R2: With `mode_moto`=0, a rising edge of `bus_wr` (active-low write strobe) while `cs_n`=0 and `bus_as`=1 loads the bus value into the address register and writes no register.
- R3: With `mode_moto`=1, a falling edge of `bus_ds` (active-high data strobe) while `cs_n`=0, `bus_wr` (read/not-write) is 0 and `bus_as`=1 loads the bus value into the address register and writes no register.
- R4: With `mode_moto`=0, a rising edge of `bus_wr` while `cs_n`=0 and `bus_as`=0 writes the bus value into the register that the address register selects.
- R5: With `mode_moto`=1, a falling edge of `bus_ds` while `cs_n`=0, `bus_wr`=0 and `bus_as`=0 writes the bus value into the selected register.
- R6: A falling edge of `bus_as` loads the bus value into the address register when `cs_n`=0 and no strobe is active. No strobe is active when `bus_ds` and `bus_wr` are both 1 with `mode_moto`=0, or when `bus_ds` is 0 with `mode_moto`=1.
- R7: `ad_oe` is 1 only while `cs_n`=0, `bus_as`=0 and a read is active. A read is active when `bus_ds` is 0 with `mode_moto`=0, or when `bus_ds` and `bus_wr` are both 1 with `mode_moto`=1. While `ad_oe` is 1, `ad_out` shows the selected register; otherwise `ad_out` is 0x00.
- R8: Strobes and address-strobe edges that occur while `cs_n`=1 neither load the address nor write any register.
- R9: The address register keeps its value across any number of data accesses. The most recent capture wins, whether it came through the R2/R3 path or the R6 path.
- R10: With `mode_moto`=1, a data-strobe pulse with `bus_wr`=1 and `bus_as`=1 leaves `ad_oe` at 0, loads no address and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_moto | input | 1 | Strobe convention: 0 = separate read/write strobes, 1 = data strobe with read/not-write |
| cs_n | input | 1 | Active-low select |
| bus_as | input | 1 | Address-strobe pin (host address bit 0 on a non-multiplexed bus) |
| bus_ds | input | 1 | Read strobe, active low (mode 0); data strobe, active high (mode 1) |
| bus_wr | input | 1 | Write strobe, active low (mode 0); read/not-write level (mode 1) |
| ad_in | input | 8 | Shared address/data bus, inbound |
| ad_out | output | 8 | Read data driven onto the bus |
| ad_oe | output | 1 | Output enable for the bus driver |

## Verification
The hardest case to reach from the ports is the difference between the two address-capture paths. In non-multiplexed use the address-strobe pin drops between the address cycle and the data cycle, and that drop must not overwrite the address just loaded. The stimulus therefore changes the pin only while the select is high, and it always follows an address write with a data access whose expected value depends on the captured address. The bench also mixes the two capture paths and issues strobes with the select high or with the wrong read/write level. Each of these is followed by a read of a register whose value differs from the wrongly targeted one, so a stray capture or write shows up as wrong data.

// File: rtl/dmbus_pkg.sv
package dmbus_pkg;

  typedef struct packed {
    logic cs_n;
    logic as;
    logic ds;
    logic wr;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{cs_n: 1'b1, as: 1'b0, ds: 1'b0, wr: 1'b0};

  function automatic logic f_read_active(input logic moto, input ctl_t c);
    return moto ? (c.ds && c.wr) : !c.ds;
  endfunction

  function automatic logic f_idle(input logic moto, input ctl_t c);
    return moto ? !c.ds : (c.ds && c.wr);
  endfunction

  function automatic logic f_oe(input logic moto, input ctl_t c);
    return !c.cs_n && !c.as && f_read_active(moto, c);
  endfunction

  function automatic logic f_xfer_end(input logic moto, input ctl_t prv, input ctl_t cur);
    logic wr_rise, ds_fall;
    wr_rise = !moto && !prv.wr && cur.wr;
    ds_fall = moto && prv.ds && !cur.ds && !prv.wr;
    return (wr_rise || ds_fall) && !prv.cs_n;
  endfunction

endpackage

// File: rtl/dmbus_sync.sv
module dmbus_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dmbus_decode.sv
module dmbus_decode
  import dmbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_moto,
  input  ctl_t ctl_s,
  output logic ev_mux_latch,
  output logic ev_nm_latch,
  output logic ev_wr_data,
  output logic oe
);
  ctl_t ctl_p;
  logic xfer_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_p <= CTL_RESET;
    else        ctl_p <= ctl_s;
  end

  assign xfer_end     = f_xfer_end(mode_moto, ctl_p, ctl_s);
  assign ev_nm_latch  = xfer_end && ctl_p.as;
  assign ev_wr_data   = xfer_end && !ctl_p.as;
  assign ev_mux_latch = !ctl_p.cs_n && ctl_p.as && !ctl_s.as && f_idle(mode_moto, ctl_p);
  assign oe           = f_oe(mode_moto, ctl_s);
endmodule

// File: rtl/dmbus_regfile.sv
module dmbus_regfile #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/dmbus_slave.sv
module dmbus_slave
  import dmbus_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_moto,
  input  logic              cs_n,
  input  logic              bus_as,
  input  logic              bus_ds,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe
);
  localparam int CTL_W = $bits(ctl_t);

  logic [CTL_W-1:0]  ctl_raw, ctl_q;
  ctl_t              ctl_s;
  logic [DATA_W-1:0] bus_s;
  logic              ev_mux_latch, ev_nm_latch, ev_wr_data;
  logic              oe;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rd_data;

  assign ctl_raw = {cs_n, bus_as, bus_ds, bus_wr};

  dmbus_sync #(.W(CTL_W), .RST_VAL(CTL_RESET)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_q)
  );

  dmbus_sync #(.W(DATA_W), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d(ad_in), .q(bus_s)
  );

  assign ctl_s = ctl_t'(ctl_q);

  dmbus_decode u_decode (
    .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto), .ctl_s(ctl_s),
    .ev_mux_latch(ev_mux_latch), .ev_nm_latch(ev_nm_latch),
    .ev_wr_data(ev_wr_data), .oe(oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         addr_q <= '0;
    else if (ev_mux_latch || ev_nm_latch) addr_q <= bus_s[ADDR_W-1:0];
  end

  dmbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(ev_wr_data), .addr(addr_q),
    .wdata(bus_s), .rdata(rd_data)
  );

  assign ad_oe  = oe;
  assign ad_out = oe ? rd_data : '0;
endmodule

// File: rtl/dmbus_slave_chk.sv
module dmbus_slave_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ad_oe,
  input logic [DATA_W-1:0] ad_out,
  input logic              ev_mux_latch,
  input logic              ev_nm_latch,
  input logic              ev_wr_data,
  input logic [ADDR_W-1:0] addr_q
);
  assert_single_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_mux_latch, ev_nm_latch, ev_wr_data}));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_mux_latch || ev_nm_latch) |=> $stable(addr_q));

  assert_oe_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> ($past(cs_n, 2) == 1'b0));

  assert_out_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe |-> (ad_out == '0));

  assert_event_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mux_latch || ev_nm_latch || ev_wr_data) |-> ($past(cs_n, 3) == 1'b0));
endmodule

bind dmbus_slave dmbus_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ad_oe(ad_oe), .ad_out(ad_out),
  .ev_mux_latch(ev_mux_latch), .ev_nm_latch(ev_nm_latch),
  .ev_wr_data(ev_wr_data), .addr_q(addr_q)
);

// File: tb/dmbus_slave_bench.sv
`timescale 1ns/1ps
module dmbus_slave_bench;
  localparam int H = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_moto = 1'b0;
  logic       cs_n = 1'b1;
  logic       bus_as = 1'b0;
  logic       bus_ds = 1'b1;
  logic       bus_wr = 1'b1;
  logic [7:0] ad_in = 8'h00;
  logic [7:0] ad_out;
  logic       ad_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] model [256];

  always #2 clk = ~clk;

  dmbus_slave u_dmbus_slave (
    .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto), .cs_n(cs_n),
    .bus_as(bus_as), .bus_ds(bus_ds), .bus_wr(bus_wr), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe)
  );

  function automatic logic [7:0] pat_a(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] pat_b(input int a);
    return 8'((a * 5) & 255) ^ 8'hC3;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    cs_n = 1'b1; bus_as = 1'b0; bus_wr = 1'b1;
    bus_ds = mode_moto ? 1'b0 : 1'b1;
  endtask

  task automatic set_mode(input logic m);
    cs_n = 1'b1; cyc(2);
    mode_moto = m; go_idle(); cyc(H);
  endtask

  task automatic strobe_write(input logic sel);
    cs_n = sel; cyc(H);
    if (mode_moto) begin bus_wr = 1'b0; cyc(1); bus_ds = 1'b1; end
    else bus_wr = 1'b0;
    cyc(H);
    chk(ad_oe == 1'b0, "R7 oe during write", ad_oe, 0);
    if (mode_moto) bus_ds = 1'b0; else bus_wr = 1'b1;
    cyc(H);
    bus_wr = 1'b1; cs_n = 1'b1; cyc(1);
    bus_as = 1'b0; cyc(H);
  endtask

  task automatic nm_addr(input logic [7:0] a);
    bus_as = 1'b1; ad_in = a; cyc(1);
    strobe_write(1'b0);
  endtask

  task automatic data_write(input logic [7:0] d);
    bus_as = 1'b0; ad_in = d; cyc(1);
    strobe_write(1'b0);
  endtask

  task automatic mux_addr(input logic [7:0] a);
    ad_in = a; cs_n = 1'b0; bus_as = 1'b1; cyc(H);
    bus_as = 1'b0; cyc(H);
    cs_n = 1'b1; cyc(H);
  endtask

  task automatic data_read(output logic [7:0] d, output logic oe);
    bus_as = 1'b0; ad_in = 8'hEE; cs_n = 1'b0; cyc(H);
    if (mode_moto) bus_ds = 1'b1; else bus_ds = 1'b0;
    cyc(H);
    d = ad_out; oe = ad_oe;
    if (mode_moto) bus_ds = 1'b0; else bus_ds = 1'b1;
    cyc(H);
    cs_n = 1'b1; cyc(H);
  endtask

  task automatic read_check(input string tag, input logic [7:0] exp);
    logic [7:0] d; logic oe;
    data_read(d, oe);
    chk(oe == 1'b1, {tag, " oe"}, oe, 1);
    chk(d == exp, tag, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    cyc(4); rst_n = 1'b1; cyc(H);

    chk(ad_oe == 1'b0, "R1 oe after reset", ad_oe, 0);
    chk(ad_out == 8'h00, "R1 out after reset", ad_out, 0);
    read_check("R1 address register reset", 8'h00);
    for (int a = 0; a < 256; a++) begin
      nm_addr(8'(a));
      read_check("R1 register reset", 8'h00);
    end

    // R2 R4 sweep in mode 0
    set_mode(1'b0);
    for (int a = 0; a < 256; a++) begin
      nm_addr(8'(a)); data_write(pat_a(a)); model[a] = pat_a(a);
    end
    for (int a = 255; a >= 0; a--) begin
      nm_addr(8'(a)); read_check("R2 R4 readback", model[a]);
    end

    // R3 R5 sweep in mode 1
    set_mode(1'b1);
    for (int a = 0; a < 256; a++) begin
      nm_addr(8'(a)); data_write(pat_b(a)); model[a] = pat_b(a);
    end
    for (int a = 0; a < 256; a++) begin
      nm_addr(8'(a)); read_check("R3 R5 readback", model[a]);
    end

    // R6 multiplexed capture in both modes
    for (int m = 0; m < 2; m++) begin
      set_mode(1'(m));
      for (int k = 0; k < 16; k++) begin
        int a = (k * 17 + m * 3) & 255;
        logic [7:0] v = 8'(a) ^ 8'h5A ^ 8'(m);
        mux_addr(8'(a)); data_write(v); model[a] = v;
      end
      for (int k = 0; k < 16; k++) begin
        int a = (k * 17 + m * 3) & 255;
        mux_addr(8'(a)); read_check("R6 mux readback", model[a]);
      end
    end

    // R9 address persists and most recent capture wins
    set_mode(1'b0);
    nm_addr(8'h21); mux_addr(8'h42); data_write(8'h99); model[8'h42] = 8'h99;
    read_check("R9 latest capture", 8'h99);
    read_check("R9 held address", 8'h99);
    mux_addr(8'h43); nm_addr(8'h21);
    read_check("R9 nm after mux", model[8'h21]);

    // R8 deselected traffic ignored
    nm_addr(8'h10);
    bus_as = 1'b1; ad_in = 8'h77; cyc(1); strobe_write(1'b1);
    bus_as = 1'b0; ad_in = 8'hAB; cyc(1); strobe_write(1'b1);
    ad_in = 8'h55; bus_as = 1'b1; cyc(H); bus_as = 1'b0; cyc(H);
    read_check("R8 addr not captured", model[8'h10]);
    nm_addr(8'h77); read_check("R8 no write", model[8'h77]);

    // R10 mode 1 read-level strobe with AS high
    set_mode(1'b1);
    nm_addr(8'h30);
    bus_as = 1'b1; ad_in = 8'h31; cs_n = 1'b0; cyc(H);
    bus_wr = 1'b1; bus_ds = 1'b1; cyc(H);
    chk(ad_oe == 1'b0, "R10 oe with as high", ad_oe, 0);
    chk(ad_out == 8'h00, "R7 R10 out quiet", ad_out, 0);
    bus_ds = 1'b0; cyc(H); cs_n = 1'b1; cyc(1); bus_as = 1'b0; cyc(H);
    read_check("R10 no capture", model[8'h30]);
    nm_addr(8'h31); read_check("R10 no write", model[8'h31]);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule